// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Adder

This block adds two 32-bit single-precision words over several clock cycles. A word carries a sign in bit 31, a biased exponent (bias 127) in bits 30:23 and a fraction in bits 22:0. A normal word has a nonzero exponent field and a significand of 1.f.

The caller pulses `start` with both operands while the block is idle. The block then puts the larger magnitude first and shifts the smaller significand right to line it up. It adds or subtracts the two 24-bit significands and normalizes the result one bit position per cycle. It then packs the result and raises `done` for one cycle.

Results are truncated, never rounded. Denormal inputs count as zero, and no denormal result is ever produced.

Top module: `fp_add_seq`

## Requirements
- R1: The result uses the operand layout: sign in bit 31, exponent field in bits 30:23 with bias 127, and fraction in bits 22:0. Adding 0xC0A00000 (-5.0) to 0x00000000 returns 0xC0A00000.
- R2: `start` is taken only while the block is idle. A `start` while an operation is in flight is ignored. `done` is high for exactly one cycle per accepted operation, and `result` holds its value until the next `done`.
- R3: The operand with the larger magnitude (bits 30:0 compared as an integer, ties going to `op_a`) comes first. The other significand is shifted right by the difference of the exponent fields, and every bit shifted out is discarded.
- R4: Operands with equal signs have their significands added. A sum of 2 or more is shifted right once and its exponent is incremented, and the bit dropped by that shift is discarded.
- R5: Operands with different signs subtract the smaller significand from the larger, and the result takes the sign of the larger magnitude. A difference below 1 is shifted left one place per cycle until bit 23 is set, and each shift decrements the exponent by one.
- R6: A zero significand sum gives 0x00000000.
- R7: An operand with exponent field 0 counts as zero, whatever its fraction.
- R8: An exponent field of 255 with a nonzero fraction is NaN. A NaN on either input gives 0x7FC00000. Infinities of opposite sign also give 0x7FC00000. Otherwise an infinite operand is returned unchanged.
- R9: A final exponent above 254 gives infinity with the result sign (exponent 255, fraction 0). A final exponent below 1 gives 0x00000000.
- R10: After reset `done` is 0 and `result` is 0. `done` rises no more than 30 cycles after `start` is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand strobe, taken when idle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| done | output | 1 | One-cycle result strobe |
| result | output | 32 | Sum, held between strobes |

## Verification
The carry renormalization and the overflow to infinity can fall in the same packing step. When two operands near the top exponent carry out, the right shift raises the exponent past 254, and the packer must then emit infinity rather than a wrapped exponent. The bench provokes this by adding operands with exponent fields 253 and 254 in the sweep, and directly with 0x7F7FFFFF + 0x7F7FFFFF. It judges the result against a bench model that computes the post-carry exponent before the range test. The same sweep puts long left-shift chains next to underflow to zero, using operands with exponent fields 1 and 2.

// File: rtl/fp_add_seq.sv
module fp_add_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        done,
  output logic [31:0] result
);
  localparam logic [31:0] QNAN = 32'h7FC00000;

  typedef enum logic [1:0] {S_IDLE, S_ADD, S_NORM, S_OUT} state_t;
  state_t st;

  logic              sgn, sub;
  logic signed [9:0] ex;
  logic [23:0]       m_big, m_sml;
  logic [24:0]       sig;

  // unpack, order by magnitude, align
  wire        a_first = op_a[30:0] >= op_b[30:0];
  wire [31:0] big     = a_first ? op_a : op_b;
  wire [31:0] sml     = a_first ? op_b : op_a;
  wire [7:0]  e_big   = big[30:23];
  wire [7:0]  e_sml   = sml[30:23];
  wire [7:0]  e_dif   = e_big - e_sml;
  wire [23:0] h_big   = (e_big != 8'd0) ? {1'b1, big[22:0]} : 24'd0;
  wire [23:0] h_sml   = (e_sml != 8'd0) ? {1'b1, sml[22:0]} : 24'd0;

  wire nan_a = (op_a[30:23] == 8'hFF) && (op_a[22:0] != 23'd0);
  wire nan_b = (op_b[30:23] == 8'hFF) && (op_b[22:0] != 23'd0);
  wire inf_a = (op_a[30:23] == 8'hFF) && (op_a[22:0] == 23'd0);
  wire inf_b = (op_b[30:23] == 8'hFF) && (op_b[22:0] == 23'd0);
  wire bad   = nan_a || nan_b || (inf_a && inf_b && (op_a[31] != op_b[31]));

  assign done = (st == S_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sgn    <= 1'b0;
      sub    <= 1'b0;
      ex     <= '0;
      m_big  <= '0;
      m_sml  <= '0;
      sig    <= '0;
      result <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (bad) begin
            result <= QNAN;
            st     <= S_OUT;
          end else if (inf_a) begin
            result <= op_a;
            st     <= S_OUT;
          end else if (inf_b) begin
            result <= op_b;
            st     <= S_OUT;
          end else begin
            sgn   <= big[31];
            sub   <= op_a[31] ^ op_b[31];
            ex    <= signed'({2'b00, e_big});
            m_big <= h_big;
            m_sml <= h_sml >> e_dif;
            st    <= S_ADD;
          end
        end
        S_ADD: begin
          sig <= sub ? ({1'b0, m_big} - {1'b0, m_sml}) : ({1'b0, m_big} + {1'b0, m_sml});
          st  <= S_NORM;
        end
        S_NORM: begin
          if (sig == 25'd0) begin
            result <= 32'd0;
            st     <= S_OUT;
          end else if (sig[24]) begin
            sig <= sig >> 1;
            ex  <= ex + 10'sd1;
          end else if (!sig[23]) begin
            sig <= sig << 1;
            ex  <= ex - 10'sd1;
          end else begin
            if (ex > 10'sd254)    result <= {sgn, 8'hFF, 23'd0};
            else if (ex < 10'sd1) result <= 32'd0;
            else                  result <= {sgn, ex[7:0], sig[22:0]};
            st <= S_OUT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_CARRY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NORM) && sig[24] |=> !sig[24] && (st == S_NORM)); // R4
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result[30:23] == 8'hFF) && (result[22:0] != 23'd0) |-> result == QNAN); // R8
  AST_NO_DENORM: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result[30:23] == 8'd0) |-> result == 32'd0); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADD) |=> $stable(result)); // R2
endmodule

// File: tb/fp_add_seq_bench.sv
module fp_add_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        done;
  logic [31:0] result;
  int checks = 0, failures = 0;

  fp_add_seq u_fp_add_seq (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
                           .op_b(op_b), .done(done), .result(result));

  always #5 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic na, nb, ia, ib, af;
    logic [31:0] bg, sm;
    longint mb, ms, s, d, e;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    ia = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    ib = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (na || nb || (ia && ib && a[31] != b[31])) return 32'h7FC00000;
    if (ia) return a;
    if (ib) return b;
    af = a[30:0] >= b[30:0];
    bg = af ? a : b;
    sm = af ? b : a;
    mb = (bg[30:23] != 0) ? (longint'(bg[22:0]) + 64'h800000) : 0;
    ms = (sm[30:23] != 0) ? (longint'(sm[22:0]) + 64'h800000) : 0;
    d  = longint'(bg[30:23]) - longint'(sm[30:23]);
    ms = (d > 40) ? 0 : ms / (longint'(1) << d);
    s  = (a[31] == b[31]) ? mb + ms : mb - ms;
    if (s == 0) return 32'd0;
    e = longint'(bg[30:23]);
    if (s >= 64'h1000000) begin s = s / 2; e = e + 1; end
    while (s < 64'h800000) begin s = s * 2; e = e - 1; end
    if (e > 254) return {bg[31], 8'hFF, 23'd0};
    if (e < 1) return 32'd0;
    return {bg[31], e[7:0], s[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input string req,
                     input logic [31:0] exp, input bit poke);
    int n;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin
      op_a = 32'h3F800000; op_b = 32'h3F800000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(req, result, exp);
    if (n > 30) check("R10 latency", 32'(n), 32'd30);
    @(negedge clk);
    if (done) check("R2 done one cycle", 32'(done), 32'd0);
    check("R2 result held", result, exp);
  endtask

  initial begin
    #1_900_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  ex_l [9];
    logic [22:0] fr_l [3];
    ex_l = '{8'd0, 8'd1, 8'd2, 8'd126, 8'd127, 8'd128, 8'd140, 8'd253, 8'd254};
    fr_l = '{23'd0, 23'd1, 23'h7FFFFF};
    #23;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset done", 32'(done), 32'd0);
    check("R10 reset result", result, 32'd0);

    run(32'hC0A00000, 32'h00000000, "R1 minus five", 32'hC0A00000, 0);
    run(32'h3F800000, 32'h3F800000, "R4 carry 1+1", 32'h40000000, 0);
    run(32'h3F800000, 32'hBF800000, "R6 cancel", 32'h00000000, 0);
    run(32'h40400000, 32'hBF800000, "R5 3-1", 32'h40000000, 0);
    run(32'hBF800000, 32'h40400000, "R5 sign of larger", 32'h40000000, 0);
    run(32'h3F800000, 32'h33800000, "R3 shifted out", 32'h3F800000, 0);
    run(32'h3F800000, 32'h007FFFFF, "R7 denormal zero", 32'h3F800000, 0);
    run(32'h7F7FFFFF, 32'h7F7FFFFF, "R9 overflow", 32'h7F800000, 0);
    run(32'h00800000, 32'h80800001, "R9 underflow", 32'h00000000, 0);
    run(32'h7FC12345, 32'h3F800000, "R8 nan", 32'h7FC00000, 0);
    run(32'h7F800000, 32'hFF800000, "R8 inf minus inf", 32'h7FC00000, 0);
    run(32'hFF800000, 32'h3F800000, "R8 inf passes", 32'hFF800000, 0);
    run(32'h40A00000, 32'h40400000, "R2 busy start ignored", 32'h41000000, 1);

    for (int i = 0; i < 54; i++) begin
      for (int j = 0; j < 54; j++) begin
        logic [31:0] a, b;
        a = {i[0], ex_l[(i / 2) % 9], fr_l[i / 18]};
        b = {j[0], ex_l[(j / 2) % 9], fr_l[j / 18]};
        run(a, b, "R3 R4 R5 sweep", model(a, b), 0);
      end
    end
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = {k[0], 8'hFF, (k > 1) ? 23'h400001 : 23'd0};
      run(a, 32'h41200000, "R8 sweep", model(a, 32'h41200000), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule